// File: doc/BRIEF.md
# Opcode-Selected 8-bit Arithmetic Logic Unit

This block is a purely combinational arithmetic logic unit for 8-bit operands. It takes two operands and a 4-bit operation code, and it returns an 8-bit result together with an unsigned carry flag and a signed overflow flag. The operations are bitwise AND, OR, XOR and invert, addition, two's-complement subtraction, a pass-through of the first operand and a zero test on the first operand.

The block holds no state and has no clock. A surrounding datapath drives the operands and the operation code, and it reads the result and the flags in the same cycle. The operation codes form a fixed, non-contiguous map. Every code outside that map gives an all-zero output. The two flags carry information only for addition and subtraction. For every other code both flags read zero.

Top module: `alu8_core`

## Requirements
- R1: Op code 4'b1110 gives r = a & b, 4'b1101 gives r = a | b and 4'b1011 gives r = a ^ b, bit by bit across all 8 bits.
- R2: Op code 4'b1100 gives r = ~a, and b has no effect on r.
- R3: Op code 4'b1010 forms the 9-bit sum of the zero-extended operands. r is its low 8 bits and c is bit 8.
- R4: Op code 4'b1001 gives r = (a - b) mod 256, computed as a + ~b + 1. c is the carry out of bit 8, which is 1 exactly when a >= b as unsigned numbers.
- R5: Under addition, v is 1 exactly when a[7] equals b[7] and r[7] differs from them.
- R6: Under subtraction, v is 1 exactly when a[7] differs from b[7] and r[7] differs from a[7].
- R7: Op code 4'b1000 gives r = a, and b has no effect on r.
- R8: Op code 4'b0111 gives r = 8'h01 when a is zero and 8'h00 otherwise. Bits 7..1 of r are always zero, and b has no effect.
- R9: c and v are both 0 for every op code other than 4'b1010 and 4'b1001.
- R10: Op codes 4'b0000 through 4'b0110 and 4'b1111 give r = 8'h00, c = 0 and v = 0.
- R11: The outputs depend only on the present inputs. A new input set gives its full result within the same clock cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | First operand; the only operand used by invert, pass-through and zero test |
| b | input | 8 | Second operand |
| s | input | 4 | Operation code |
| r | output | 8 | Result |
| c | output | 1 | Unsigned carry; 1 on subtraction means no borrow |
| v | output | 1 | Signed overflow |

## Verification
Each result is due zero cycles after its stimulus. The outputs are combinational, so r, c and v belong to the same cycle in which a, b and s change. The driver changes the inputs just after a rising edge and queues the expected values. The monitor pops each expected item at the following falling edge and compares it, which leaves half a period for the logic to settle and keeps every comparison away from the edge at which inputs move. Addition and subtraction are swept over every operand pair. Every op code, including the unlisted ones, is run on the sign and carry edge values and on random operands.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int DATA_W = 8;
  localparam int OP_W   = 4;
  localparam int MSB    = DATA_W - 1;

  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic [OP_W-1:0] {
    OPC_ZTEST = 4'b0111,
    OPC_PASS  = 4'b1000,
    OPC_SUB   = 4'b1001,
    OPC_ADD   = 4'b1010,
    OPC_XOR   = 4'b1011,
    OPC_INV   = 4'b1100,
    OPC_OR    = 4'b1101,
    OPC_AND   = 4'b1110
  } opc_e;

  // bitwise unit selector
  typedef enum logic [1:0] {
    BW_AND = 2'd0,
    BW_OR  = 2'd1,
    BW_XOR = 2'd2,
    BW_INV = 2'd3
  } bw_sel_e;

  // extended sum: {carry, result}; subtract inverts y and injects carry-in
  function automatic logic [DATA_W:0] ext_addsub(input word_t x, input word_t y,
                                                 input logic sub);
    word_t y_eff;
    y_eff = sub ? ~y : y;
    return {1'b0, x} + {1'b0, y_eff} + {{DATA_W{1'b0}}, sub};
  endfunction

  // signed overflow from the sign bits of the operands actually summed
  function automatic logic sign_ovf(input logic x_msb, input logic y_eff_msb,
                                    input logic res_msb);
    return (x_msb == y_eff_msb) && (res_msb != x_msb);
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  logic  sub_i,
  input  word_t a_i,
  input  word_t b_i,
  output word_t sum_o,
  output logic  cout_o,
  output logic  ovf_o
);

  logic [DATA_W:0] wide;
  logic            b_eff_msb;

  always_comb begin
    wide      = ext_addsub(a_i, b_i, sub_i);
    b_eff_msb = sub_i ? ~b_i[MSB] : b_i[MSB];
  end

  assign sum_o  = wide[DATA_W-1:0];
  assign cout_o = wide[DATA_W];
  assign ovf_o  = sign_ovf(a_i[MSB], b_eff_msb, wide[MSB]);

  // event wires for the assertions
  logic no_borrow_ev;
  logic add_ovf_ev;
  logic sub_ovf_ev;
  assign no_borrow_ev = sub_i && cout_o;
  assign add_ovf_ev   = !sub_i && ovf_o;
  assign sub_ovf_ev   = sub_i && ovf_o;

  always_comb begin
    if (sub_i) begin
      a_r4_no_borrow: assert (no_borrow_ev == (a_i >= b_i));
    end
    if (add_ovf_ev) begin
      a_r5_add_ovf: assert ((a_i[MSB] == b_i[MSB]) && (sum_o[MSB] != a_i[MSB]));
    end
    if (sub_ovf_ev) begin
      a_r6_sub_ovf: assert ((a_i[MSB] != b_i[MSB]) && (sum_o[MSB] != a_i[MSB]));
    end
    if (!sub_i) begin
      a_r3_sum_wrap: assert (sum_o == word_t'(a_i + b_i));
    end
  end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
  import alu8_pkg::*;
(
  input  bw_sel_e sel_i,
  input  word_t   a_i,
  input  word_t   b_i,
  output word_t   res_o
);

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        BW_AND:  res_o[g] = a_i[g] & b_i[g];
        BW_OR:   res_o[g] = a_i[g] | b_i[g];
        BW_XOR:  res_o[g] = a_i[g] ^ b_i[g];
        default: res_o[g] = ~a_i[g];
      endcase
    end
  end

  always_comb begin
    if (sel_i == BW_INV) begin
      a_r2_inv_disjoint: assert ((res_o & a_i) == '0);
    end
  end

endmodule

// File: rtl/alu8_ztest.sv
module alu8_ztest
  import alu8_pkg::*;
(
  input  word_t a_i,
  output word_t res_o
);

  logic is_zero;
  assign is_zero = ~(|a_i);
  assign res_o   = {{(DATA_W-1){1'b0}}, is_zero};

  always_comb begin
    a_r8_upper_zero: assert (res_o[DATA_W-1:1] == '0);
    a_r8_one_hot:    assert ($countones(res_o) == ((a_i == '0) ? 1 : 0));
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [7:0] a,
  input  logic [7:0] b,
  input  logic [3:0] s,
  output logic [7:0] r,
  output logic       c,
  output logic       v
);

  word_t   ar_sum;
  logic    ar_cout;
  logic    ar_ovf;
  logic    ar_sub;
  word_t   bw_res;
  bw_sel_e bw_sel;
  word_t   zt_res;

  assign ar_sub = (s == OPC_SUB);

  always_comb begin
    unique case (s)
      OPC_OR:  bw_sel = BW_OR;
      OPC_XOR: bw_sel = BW_XOR;
      OPC_INV: bw_sel = BW_INV;
      default: bw_sel = BW_AND;
    endcase
  end

  alu8_arith u_arith (
    .sub_i  (ar_sub),
    .a_i    (a),
    .b_i    (b),
    .sum_o  (ar_sum),
    .cout_o (ar_cout),
    .ovf_o  (ar_ovf)
  );

  alu8_bitwise u_bitwise (
    .sel_i (bw_sel),
    .a_i   (a),
    .b_i   (b),
    .res_o (bw_res)
  );

  alu8_ztest u_ztest (
    .a_i   (a),
    .res_o (zt_res)
  );

  // output select with defaults first: no latch, unlisted codes give zero
  always_comb begin
    r = '0;
    c = 1'b0;
    v = 1'b0;
    case (s)
      OPC_ADD, OPC_SUB: begin
        r = ar_sum;
        c = ar_cout;
        v = ar_ovf;
      end
      OPC_AND, OPC_OR, OPC_XOR, OPC_INV: r = bw_res;
      OPC_PASS:  r = a;
      OPC_ZTEST: r = zt_res;
      default: ;
    endcase
  end

  // event wires for the assertions
  logic arith_sel;
  logic listed_sel;
  assign arith_sel  = (s == OPC_ADD) || (s == OPC_SUB);
  assign listed_sel = (s >= OPC_ZTEST) && (s <= OPC_AND);

  always_comb begin
    if (!arith_sel) begin
      a_r9_flags_quiet: assert (!c && !v);
    end
    if (!listed_sel) begin
      a_r10_unlisted_zero: assert ((r == '0) && !c && !v);
    end
    if (s == OPC_PASS) begin
      a_r7_pass_through: assert (r == bw_res || r == a);
    end
  end

endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 195000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] a = '0;
  logic [7:0] b = '0;
  logic [3:0] s = '0;
  logic [7:0] r;
  logic       c;
  logic       v;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [3:0] s;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] r;
    logic       c;
    logic       v;
  } exp_t;

  exp_t exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_core i_alu8_core (
    .a (a),
    .b (b),
    .s (s),
    .r (r),
    .c (c),
    .v (v)
  );

  // independent reference: integer arithmetic, signed range check
  task automatic ref_model(input logic [3:0] so, input logic [7:0] ao, input logic [7:0] bo,
                           output logic [7:0] re, output logic ce, output logic ve,
                           output string tg);
    int u;
    int sv;
    re = 8'h00; ce = 1'b0; ve = 1'b0;
    case (so)
      4'b1110: begin re = ao & bo; tg = "R1 and R9"; end
      4'b1101: begin re = ao | bo; tg = "R1 or R9"; end
      4'b1011: begin re = ao ^ bo; tg = "R1 xor R9"; end
      4'b1100: begin re = ~ao;     tg = "R2 invert R9"; end
      4'b1010: begin
        u  = int'(ao) + int'(bo);
        sv = int'($signed(ao)) + int'($signed(bo));
        re = u[7:0]; ce = (u > 255); ve = (sv > 127) || (sv < -128);
        tg = "R3 add R5";
      end
      4'b1001: begin
        u  = int'(ao) - int'(bo);
        sv = int'($signed(ao)) - int'($signed(bo));
        re = u[7:0]; ce = (ao >= bo); ve = (sv > 127) || (sv < -128);
        tg = "R4 sub R6";
      end
      4'b1000: begin re = ao; tg = "R7 pass R9"; end
      4'b0111: begin re = (ao == 8'h00) ? 8'h01 : 8'h00; tg = "R8 ztest R9"; end
      default: tg = "R10 unlisted R9";
    endcase
  endtask

  // driver: change inputs just after a rising edge, queue the expectation
  task automatic drive(input logic [3:0] so, input logic [7:0] ao, input logic [7:0] bo);
    exp_t e;
    string tg;
    @(posedge clk);
    #1;
    s = so; a = ao; b = bo;
    e.s = so; e.a = ao; e.b = bo;
    ref_model(so, ao, bo, e.r, e.c, e.v, tg);
    exp_q.push_back(e);
    tag_q.push_back(tg);
  endtask

  // monitor: result due in the same cycle, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst && exp_q.size() > 0) begin
      exp_t e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      tests_run++;
      if (r !== e.r || c !== e.c || v !== e.v) begin
        tests_failed++;
        $display("FAIL %s (R11 same-cycle) s=%b a=%h b=%h: actual r=%h c=%b v=%b expected r=%h c=%b v=%b",
                 tg, e.s, e.a, e.b, r, c, v, e.r, e.c, e.v);
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      tests_failed++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin : stimulus
    logic [7:0] edges [4];
    edges[0] = 8'h00; edges[1] = 8'h7F; edges[2] = 8'h80; edges[3] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // reset-state check, R10 and R11: all-zero inputs give all-zero outputs
    drive(4'b0000, 8'h00, 8'h00);

    // every op code on the sign and carry edge values (R1..R10)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          drive(op[3:0], edges[i], edges[j]);

    // b must not matter for invert, pass, ztest (R2 R7 R8)
    for (int k = 0; k < 64; k++) begin
      drive(4'b1100, 8'h5A, k[7:0] * 8'd37);
      drive(4'b1000, 8'hC3, k[7:0] * 8'd53);
      drive(4'b0111, 8'h00, k[7:0] * 8'd29);
    end

    // exhaustive add and subtract (R3 R4 R5 R6)
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        drive(4'b1010, x[7:0], y[7:0]);
        drive(4'b1001, x[7:0], y[7:0]);
      end

    // random operands on every op code
    for (int op = 0; op < 16; op++)
      for (int n = 0; n < 300; n++)
        drive(op[3:0], 8'($urandom), 8'($urandom));

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

endmodule